// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block sits on the controller side of a synchronous DRAM and, after reset, walks the memory through its mandatory start-up ritual. It first holds the bus quiet (clock enable high, both byte masks high, no-operation command) for a long stabilisation window. It then closes all banks, runs a programmable number of auto-refresh cycles, and finally loads the mode word that fixes read latency, burst ordering and burst length. Each step is separated by the minimum recovery time of the previous one.

Every delay is a parameter expressed in clock cycles, so the same RTL can run with real datasheet-derived counts in silicon and with tiny counts in simulation. Once the last recovery window has run out, a ready flag rises and stays high until the next reset. At that point the normal memory controller takes over the command bus. Pulling reset low at any moment aborts whatever step is in progress and starts the whole sequence again from the quiet hold.

Top module: `sdram_init_seq`

## Requirements
- R1: For the first HOLD_CYC cycles after reset release the command is no-operation ({cs_n,ras_n,cas_n,we_n}=0111), address and bank are zero and ready_o is low.
- R2: In cycle HOLD_CYC (counting from 0 at reset release) a close-all-banks command is driven: {cs_n,ras_n,cas_n,we_n}=0010 with address bit 8 high, all other address bits and the bank bit low.
- R3: The first auto-refresh ({cs_n,ras_n,cas_n,we_n}=0001, address and bank zero) is driven exactly PRE_CYC cycles after the close-all command.
- R4: Exactly REF_COUNT auto-refresh commands are driven, consecutive ones exactly REF_CYC cycles apart; REF_COUNT is at least 8.
- R5: The mode load ({cs_n,ras_n,cas_n,we_n}=0000, bank 0) is driven exactly REF_CYC cycles after the last refresh, with address bits 8 and 7 low, bits 6..4 the latency, bit 3 the burst type (0 sequential, 1 interleaved) and bits 2..0 the burst-length code.
- R6: Latency codes are 001 for 1, 010 for 2, 011 for 3; burst-length codes are 000 for 1, 001 for 2, 010 for 4, 011 for 8 and 111 for a full row.
- R7: ready_o rises exactly MRS_CYC cycles after the mode load, stays high until reset, and no-operation is driven from then on.
- R8: Each command lasts one cycle; every cycle between commands carries no-operation with zero address and bank.
- R9: Asserting rst_ni low at any time drops ready_o, forces no-operation, and after release the sequence restarts from R1.
- R10: cke_o is high and dqm_o is 11 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| bank_o | output | 1 | Bank select |
| addr_o | output | ADDR_W | Address / mode word |
| dqm_o | output | 2 | Byte masks, upper and lower |
| ready_o | output | 1 | Sequence complete |

## Verification
The two events that can coincide are the expiry of a step's wait counter and an asynchronous reset; the bench provokes this by pulling reset low partway through the refresh train and again after ready has risen, then replays the full timeline. Every cycle of each run is compared against a timeline computed arithmetically from the four delay parameters and the refresh count, so a restart that resumes mid-sequence, a lost refresh, or an off-by-one wait shows up at the exact cycle. Two extra instances with different mode settings are checked at their mode-load cycle to cover the latency and length encodings.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // values are {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_PALL = 4'b0010,
    CMD_REF  = 4'b0001,
    CMD_MRS  = 4'b0000
  } cmd_e;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_PALL,
    ST_REF,
    ST_MRS,
    ST_DONE
  } state_e;

  function automatic logic [2:0] lat_code(int lat);
    case (lat)
      1:       return 3'b001;
      2:       return 3'b010;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [2:0] len_code(int len);
    case (len)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= W'(RST_VAL);
    else if (load_i)                 cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4: an expired counter stays expired until reloaded
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o && !load_i |=> zero_o);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  cmd_e              cmd_i,
  input  logic [6:0]        mode_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              bank_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_i;
    bank_o = 1'b0;
    addr_o = '0;
    case (cmd_i)
      CMD_PALL: addr_o[8]   = 1'b1;
      CMD_MRS:  addr_o[6:0] = mode_i;
      default:  ;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int HOLD_CYC   = 50000,
  parameter int PRE_CYC    = 3,
  parameter int REF_CYC    = 8,
  parameter int MRS_CYC    = 2,
  parameter int REF_COUNT  = 8,
  parameter int CAS_LAT    = 2,
  parameter int BURST_TYPE = 0,
  parameter int BURST_LEN  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        dqm_o,
  output logic              ready_o
);

  localparam int MAX_AB = (HOLD_CYC > PRE_CYC) ? HOLD_CYC : PRE_CYC;
  localparam int MAX_CD = (REF_CYC > MRS_CYC) ? REF_CYC : MRS_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int REF_W  = $clog2(REF_COUNT + 1);
  localparam logic [6:0] MODE_WORD =
    {lat_code(CAS_LAT), BURST_TYPE[0], len_code(BURST_LEN)};

  state_e           state_q, state_d;
  logic             first_q, first_d;
  logic             tmr_ld, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             ref_ld, ref_en, ref_zero;
  cmd_e             cmd;

  sdram_init_timer #(.W(CNT_W), .RST_VAL(HOLD_CYC - 1)) i_wait_tmr (
    .clk_i, .rst_ni,
    .en_i      (1'b1),
    .load_i    (tmr_ld),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  sdram_init_timer #(.W(REF_W), .RST_VAL(0)) i_ref_cnt (
    .clk_i, .rst_ni,
    .en_i      (ref_en),
    .load_i    (ref_ld),
    .load_val_i(REF_W'(REF_COUNT - 1)),
    .zero_o    (ref_zero)
  );

  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    ref_ld  = 1'b0;
    ref_en  = 1'b0;
    if (tmr_zero) begin
      unique case (state_q)
        ST_HOLD: begin
          state_d = ST_PALL;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(PRE_CYC - 1);
        end
        ST_PALL: begin
          state_d = ST_REF;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(REF_CYC - 1);
          ref_ld  = 1'b1;
        end
        ST_REF: begin
          tmr_ld = 1'b1;
          if (ref_zero) begin
            state_d = ST_MRS;
            tmr_val = CNT_W'(MRS_CYC - 1);
          end else begin
            tmr_val = CNT_W'(REF_CYC - 1);
            ref_en  = 1'b1;
          end
        end
        ST_MRS:  state_d = ST_DONE;
        default: ;
      endcase
    end
  end

  // a command goes out only in the first cycle of its step
  assign first_d = tmr_zero && (state_q inside {ST_HOLD, ST_PALL, ST_REF});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    if (first_q) begin
      case (state_q)
        ST_PALL: cmd = CMD_PALL;
        ST_REF:  cmd = CMD_REF;
        ST_MRS:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  sdram_init_cmd_enc #(.ADDR_W(ADDR_W)) i_enc (
    .cmd_i  (cmd),
    .mode_i (MODE_WORD),
    .cs_n_o,
    .ras_n_o,
    .cas_n_o,
    .we_n_o,
    .bank_o,
    .addr_o
  );

  assign cke_o   = 1'b1;
  assign dqm_o   = 2'b11;
  assign ready_o = (state_q == ST_DONE);

  // R7: once up, stays up
  a_r7_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  // R8: any command is followed by a no-operation
  a_r8_single_cycle_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ras_n_o && cas_n_o && we_n_o) |=> (ras_n_o && cas_n_o && we_n_o));

  // R2: close-all carries the all-banks address bit
  a_r2_pall_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0010) |-> addr_o[8] && !bank_o);

  // R5: mode load keeps the reserved bits low
  a_r5_mode_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000) |-> (addr_o[8:7] == 2'b00) && !bank_o);

  // R7: no command while ready
  a_r7_quiet_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int H = 5, P = 3, C = 4, M = 2, R = 8;
  localparam int T_MRS  = H + P + R * C;
  localparam int T_RDY  = T_MRS + M;
  localparam int T_FULL = T_RDY + 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  logic       cke, cs_n, ras_n, cas_n, we_n, bank, ready;
  logic [8:0] addr;
  logic [1:0] dqm;
  logic       a_cs, a_ras, a_cas, a_we, a_bank, a_cke, a_rdy;
  logic [8:0] a_addr;
  logic [1:0] a_dqm;
  logic       b_cs, b_ras, b_cas, b_we, b_bank, b_cke, b_rdy;
  logic [8:0] b_addr;
  logic [1:0] b_dqm;

  sdram_init_seq #(.HOLD_CYC(H), .PRE_CYC(P), .REF_CYC(C), .MRS_CYC(M), .REF_COUNT(R),
                   .CAS_LAT(3), .BURST_TYPE(1), .BURST_LEN(4)) i_sdram_init_seq (
    .clk_i(clk), .rst_ni, .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .bank_o(bank), .addr_o(addr), .dqm_o(dqm), .ready_o(ready));

  sdram_init_seq #(.HOLD_CYC(H), .PRE_CYC(P), .REF_CYC(C), .MRS_CYC(M), .REF_COUNT(R),
                   .CAS_LAT(2), .BURST_TYPE(0), .BURST_LEN(256)) i_sdram_init_seq_a (
    .clk_i(clk), .rst_ni, .cke_o(a_cke), .cs_n_o(a_cs), .ras_n_o(a_ras), .cas_n_o(a_cas),
    .we_n_o(a_we), .bank_o(a_bank), .addr_o(a_addr), .dqm_o(a_dqm), .ready_o(a_rdy));

  sdram_init_seq #(.HOLD_CYC(H), .PRE_CYC(P), .REF_CYC(C), .MRS_CYC(M), .REF_COUNT(R),
                   .CAS_LAT(1), .BURST_TYPE(1), .BURST_LEN(8)) i_sdram_init_seq_b (
    .clk_i(clk), .rst_ni, .cke_o(b_cke), .cs_n_o(b_cs), .ras_n_o(b_ras), .cas_n_o(b_cas),
    .we_n_o(b_we), .bank_o(b_bank), .addr_o(b_addr), .dqm_o(b_dqm), .ready_o(b_rdy));

  task automatic chk(string req, int act, int exp, int c);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, c, act, exp);
    end
  endtask

  // expected timeline, cycle 0 = window after reset release
  task automatic check_cycle(int c);
    int pins, ad; string req;
    int t;
    pins = 4'b0111; ad = 0; req = "R8";
    t = c - H - P;
    if (c < H) req = "R1";
    else if (c == H) begin pins = 4'b0010; ad = 9'h100; req = "R2"; end
    else if (t >= 0 && t < R * C && t % C == 0) begin
      pins = 4'b0001; req = (t == 0) ? "R3" : "R4";
    end else if (c == T_MRS) begin pins = 4'b0000; ad = 9'h03A; req = "R5"; end
    else if (c >= T_RDY) req = "R7";
    chk(req, {cs_n, ras_n, cas_n, we_n}, pins, c);
    chk(req, addr, ad, c);
    chk(req, bank, 0, c);
    chk("R7", ready, (c >= T_RDY) ? 1 : 0, c);
    chk("R10", {cke, dqm}, 3'b111, c);
    if (c == T_MRS) begin
      // R6: lat 2 -> 010, sequential, full row -> 111 ; lat 1 -> 001, interleaved, 8 -> 011
      chk("R6", {a_cs, a_ras, a_cas, a_we}, 0, c);
      chk("R6", {a_bank, a_addr}, 10'h027, c);
      chk("R6", {b_cs, b_ras, b_cas, b_we}, 0, c);
      chk("R6", {b_bank, b_addr}, 10'h01B, c);
    end
    if (c == T_RDY) chk("R7", {a_rdy, b_rdy, a_cke, b_cke, a_dqm, b_dqm}, 8'hFF, c);
  endtask

  task automatic sweep(int n);
    for (int c = 0; c < n; c++) begin
      #5;
      check_cycle(c);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #5;
    chk("R9", ready, 0, -1);
    chk("R9", {cs_n, ras_n, cas_n, we_n}, 4'b0111, -1);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    sweep(T_FULL);
    // R9: reset in the middle of the refresh train
    do_reset();
    sweep(H + P + 3 * C + 1);
    do_reset();
    sweep(T_FULL);
    // R9: reset after ready
    do_reset();
    sweep(T_FULL);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule